// File: doc/BRIEF.md
# Link Test Command Sequencer

This block sits between a link-test controller and a command handshake engine. The controller asks for one high-level test operation at a time. Examples are choosing a loopback path, picking a pseudo-random pattern, flipping the transmit or receive polarity, starting or stopping a bit-error measurement, injecting errors, or reading back the error count. The sequencer turns each request into one or more 32-bit command words. It presents them one at a time on a request/done interface and waits for the engine to finish each one before it moves on.

Most operations map to a single command. Error injection takes two commands: a count load, then an enable. The result read takes three commands that fetch the low, middle and high parts of the error counter. The three parts are joined into one wide count, which changes only once all three reads have completed. Status reads return the full reply word. An error from the engine stops the operation at once and is reported to the controller.

Top module: `link_test_seq`

## Requirements
- R1: After reset, `op_ready` is 1, `cmd_req` is 0, and `result_cnt` and `status_word` are 0.
- R2: Every command word has this layout: data code in [31:16], 1 in bit 15, 0 in bit 14, the SET flag in bit 13, 0 in bit 12, the lane in [11:8] and the opcode in [7:0]. While a command is in flight, `cmd_req` stays high and `cmd_word` stays unchanged until `cmd_done` or `cmd_err` arrives.
- R3: Kind 0 (loopback) issues one SET command with opcode 0x40. The data code depends on `op_arg[1:0]`: 0 gives 0x0 (off), 1 gives 0x6 (serial), 2 gives 0x4 (transmit-to-receive parallel) and 3 gives 0x3 (receive-to-transmit parallel).
- R4: Kind 1 (pattern) issues one SET command with opcode 0x41. The data code depends on `op_arg[2:0]`: 0..5 give 0x208, 0x249, 0x965, 0xA69, 0x2CB and 0x30C, for the 7, 9, 13, 15, 23 and 31-bit patterns in that order. Values 6 and 7 are rejected with `op_err` and issue no command.
- R5: Kind 2 issues one SET command with opcode 0x65 (transmit polarity). Kind 3 issues one SET command with opcode 0x66 (receive polarity). For both, the data code is `op_arg[0]`: 1 inverts and 0 restores.
- R6: Kind 4 issues opcode 0x0F with data 0x20 (measurement start). Kind 5 issues opcode 0x0F with data 0x21 (stop). Kind 8 issues opcode 0x41 with data 0x0 (finish). All three are SET commands.
- R7: Kind 6 issues two SET commands in order: opcode 0x42 with data `op_arg`, then opcode 0x0F with data 0x23.
- R8: Kind 7 issues three GET commands with data 0, in the order 0x4A, 0x4B, 0x4C. Bits [15:0] of the three replies form `result_cnt` as {third, second, first}. `result_cnt` changes only together with the `op_done` pulse of that operation.
- R9: Kind 9 issues one GET command with opcode 0x49 (test status). Kind 10 issues one GET command with opcode 0x0D (PMA status). Both use data 0. The full reply is stored in `status_word`.
- R10: Between two commands of one operation, `cmd_req` is low for at least one cycle.
- R11: A `cmd_err` ends the operation. No further command is issued, `op_err` pulses for one cycle, `op_done` does not pulse, and `result_cnt` keeps its value.
- R12: Kinds 11 to 15 are rejected with an `op_err` pulse and issue no command.
- R13: `cmd_done` and `cmd_err` have no effect while `cmd_req` is low. While an operation runs, `op_ready` is low and new requests are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request, taken when `op_ready` is high |
| op_kind | input | 4 | Operation kind, encoded as 0..10 per R3 to R9 |
| op_arg | input | 16 | Mode, pattern, polarity or error count argument |
| op_lane | input | 4 | Lane number placed in the command word |
| op_ready | output | 1 | Sequencer idle and able to take an operation |
| op_done | output | 1 | One-cycle pulse when an operation completes |
| op_err | output | 1 | One-cycle pulse when an operation is rejected or aborted |
| cmd_req | output | 1 | Command request to the handshake engine |
| cmd_word | output | 32 | Command word presented with `cmd_req` |
| cmd_done | input | 1 | Engine completed the current command |
| cmd_err | input | 1 | Engine failed the current command |
| cmd_rdata | input | 32 | Reply word, valid with `cmd_done` |
| result_cnt | output | PART_W*NUM_PARTS | Assembled error count (48 bits by default) |
| status_word | output | 32 | Last status reply |

## Verification
The bench builds the block with its defaults, 16-bit parts and three of them. This makes the full 48-bit count assembly and the three-read ordering observable. The engine model fills the upper half of each reply with random bits, so taking the wrong half of a reply shows up in the count. Random engine latency, aborts on any step of two- and three-command operations, and stray completions while idle all become reachable.

// File: rtl/lt_seq_pkg.sv
`timescale 1ns/1ps
package lt_seq_pkg;

    localparam int WORD_W = 32;
    localparam int CODE_W = 16;
    localparam int LANE_W = 4;
    localparam int OPC_W  = 8;
    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        OK_LOOPBACK   = 4'd0,
        OK_PATTERN    = 4'd1,
        OK_TX_POL     = 4'd2,
        OK_RX_POL     = 4'd3,
        OK_MEAS_START = 4'd4,
        OK_MEAS_STOP  = 4'd5,
        OK_INJECT     = 4'd6,
        OK_READ_RES   = 4'd7,
        OK_FINISH     = 4'd8,
        OK_TEST_STAT  = 4'd9,
        OK_PMA_STAT   = 4'd10
    } op_kind_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              svc;
        logic              in_rst;
        logic              set;
        logic              rsvd;
        logic [LANE_W-1:0] lane;
        logic [OPC_W-1:0]  opc;
    } cmd_word_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              set;
        logic [OPC_W-1:0]  opc;
        logic              is_part;
        logic              is_stat;
    } step_t;

    localparam logic [OPC_W-1:0] OPC_LOOP    = 8'h40;
    localparam logic [OPC_W-1:0] OPC_PATTERN = 8'h41;
    localparam logic [OPC_W-1:0] OPC_TXPOL   = 8'h65;
    localparam logic [OPC_W-1:0] OPC_RXPOL   = 8'h66;
    localparam logic [OPC_W-1:0] OPC_MEAS    = 8'h0F;
    localparam logic [OPC_W-1:0] OPC_ERRNUM  = 8'h42;
    localparam logic [OPC_W-1:0] OPC_PART0   = 8'h4A;
    localparam logic [OPC_W-1:0] OPC_TSTAT   = 8'h49;
    localparam logic [OPC_W-1:0] OPC_PSTAT   = 8'h0D;

    localparam logic [CODE_W-1:0] CODE_START  = 16'h0020;
    localparam logic [CODE_W-1:0] CODE_STOP   = 16'h0021;
    localparam logic [CODE_W-1:0] CODE_INJ_EN = 16'h0023;

    function automatic logic [CODE_W-1:0] loop_code(input logic [1:0] mode);
        case (mode)
            2'd1:    return 16'h0006;
            2'd2:    return 16'h0004;
            2'd3:    return 16'h0003;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] pattern_code(input logic [2:0] sel);
        case (sel)
            3'd0:    return 16'h0208;
            3'd1:    return 16'h0249;
            3'd2:    return 16'h0965;
            3'd3:    return 16'h0A69;
            3'd4:    return 16'h02CB;
            3'd5:    return 16'h030C;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input step_t st,
                                                    input logic [LANE_W-1:0] lane);
        cmd_word_t w;
        w.code   = st.code;
        w.svc    = 1'b1;
        w.in_rst = 1'b0;
        w.set    = st.set;
        w.rsvd   = 1'b0;
        w.lane   = lane;
        w.opc    = st.opc;
        return w;
    endfunction

endpackage

// File: rtl/lt_step_decode.sv
`timescale 1ns/1ps
module lt_step_decode
    import lt_seq_pkg::*;
#(
    parameter int NUM_PARTS = 3,
    parameter int STEP_W    = 2
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [CODE_W-1:0] arg,
    input  logic [STEP_W-1:0] step,
    output step_t             st,
    output logic              last,
    output logic              legal
);
    localparam logic [STEP_W-1:0] LAST_PART = STEP_W'(NUM_PARTS - 1);

    always_comb begin
        st    = '0;
        last  = 1'b1;
        legal = 1'b1;
        case (kind)
            OK_LOOPBACK: begin
                st.code = loop_code(arg[1:0]);
                st.set  = 1'b1;
                st.opc  = OPC_LOOP;
            end
            OK_PATTERN: begin
                st.code = pattern_code(arg[2:0]);
                st.set  = 1'b1;
                st.opc  = OPC_PATTERN;
                legal   = (arg[2:0] <= 3'd5);
            end
            OK_TX_POL, OK_RX_POL: begin
                st.code = {{(CODE_W-1){1'b0}}, arg[0]};
                st.set  = 1'b1;
                st.opc  = (kind == OK_TX_POL) ? OPC_TXPOL : OPC_RXPOL;
            end
            OK_MEAS_START, OK_MEAS_STOP: begin
                st.code = (kind == OK_MEAS_START) ? CODE_START : CODE_STOP;
                st.set  = 1'b1;
                st.opc  = OPC_MEAS;
            end
            OK_INJECT: begin
                st.set = 1'b1;
                if (step == '0) begin
                    st.code = arg;
                    st.opc  = OPC_ERRNUM;
                    last    = 1'b0;
                end else begin
                    st.code = CODE_INJ_EN;
                    st.opc  = OPC_MEAS;
                end
            end
            OK_READ_RES: begin
                st.opc     = OPC_PART0 + OPC_W'(step);
                st.is_part = 1'b1;
                last       = (step == LAST_PART);
            end
            OK_FINISH: begin
                st.set = 1'b1;
                st.opc = OPC_PATTERN;
            end
            OK_TEST_STAT: begin
                st.opc     = OPC_TSTAT;
                st.is_stat = 1'b1;
            end
            OK_PMA_STAT: begin
                st.opc     = OPC_PSTAT;
                st.is_stat = 1'b1;
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/lt_seq_ctrl.sv
`timescale 1ns/1ps
module lt_seq_ctrl #(
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              legal,
    input  logic              last,
    input  logic              cmd_done,
    input  logic              cmd_err,
    output logic              idle,
    output logic              accept,
    output logic              hit,
    output logic              cmd_req,
    output logic [STEP_W-1:0] step,
    output logic              op_done,
    output logic              op_err
);
    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_GAP} state_e;
    state_e state;

    assign idle    = (state == ST_IDLE);
    assign accept  = idle && op_valid && legal;
    assign cmd_req = (state == ST_REQ);
    assign hit     = cmd_req && cmd_done && !cmd_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            step    <= '0;
            op_done <= 1'b0;
            op_err  <= 1'b0;
        end else begin
            op_done <= 1'b0;
            op_err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (op_valid) begin
                        if (legal) begin
                            state <= ST_REQ;
                            step  <= '0;
                        end else begin
                            op_err <= 1'b1;
                        end
                    end
                end
                ST_REQ: begin
                    if (cmd_err) begin
                        state  <= ST_IDLE;
                        op_err <= 1'b1;
                    end else if (cmd_done) begin
                        if (last) begin
                            state   <= ST_IDLE;
                            op_done <= 1'b1;
                        end else begin
                            state <= ST_GAP;
                            step  <= step + 1'b1;
                        end
                    end
                end
                ST_GAP:  state <= ST_REQ;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lt_part_collect.sv
`timescale 1ns/1ps
module lt_part_collect #(
    parameter int PART_W    = 16,
    parameter int NUM_PARTS = 3,
    parameter int STEP_W    = 2,
    localparam int HOLD_W   = PART_W * (NUM_PARTS - 1),
    localparam int RES_W    = PART_W * NUM_PARTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [STEP_W-1:0] cap_idx,
    input  logic [PART_W-1:0] cap_data,
    input  logic              commit,
    output logic [RES_W-1:0]  total
);
    logic [HOLD_W-1:0] hold_flat;

    for (genvar i = 0; i < NUM_PARTS - 1; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_flat[i*PART_W +: PART_W] <= '0;
            end else if (cap_en && cap_idx == STEP_W'(i)) begin
                hold_flat[i*PART_W +: PART_W] <= cap_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            total <= '0;
        end else if (commit) begin
            total <= {cap_data, hold_flat};
        end
    end
endmodule

// File: rtl/link_test_seq.sv
`timescale 1ns/1ps
module link_test_seq
    import lt_seq_pkg::*;
#(
    parameter int PART_W    = 16,
    parameter int NUM_PARTS = 3,
    localparam int RES_W    = PART_W * NUM_PARTS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [KIND_W-1:0]   op_kind,
    input  logic [CODE_W-1:0]   op_arg,
    input  logic [LANE_W-1:0]   op_lane,
    output logic                op_ready,
    output logic                op_done,
    output logic                op_err,
    output logic                cmd_req,
    output logic [WORD_W-1:0]   cmd_word,
    input  logic                cmd_done,
    input  logic                cmd_err,
    input  logic [WORD_W-1:0]   cmd_rdata,
    output logic [RES_W-1:0]    result_cnt,
    output logic [WORD_W-1:0]   status_word
);
    localparam int STEP_W = (NUM_PARTS > 2) ? $clog2(NUM_PARTS) : 1;

    logic [KIND_W-1:0] lat_kind;
    logic [CODE_W-1:0] lat_arg;
    logic [LANE_W-1:0] lat_lane;

    logic [KIND_W-1:0] dec_kind;
    logic [CODE_W-1:0] dec_arg;
    logic [LANE_W-1:0] dec_lane;
    logic [STEP_W-1:0] step;
    step_t             st;
    logic              last, legal;
    logic              idle, accept, hit;

    assign dec_kind = idle ? op_kind : lat_kind;
    assign dec_arg  = idle ? op_arg  : lat_arg;
    assign dec_lane = idle ? op_lane : lat_lane;

    lt_step_decode #(.NUM_PARTS(NUM_PARTS), .STEP_W(STEP_W)) u_dec (
        .kind  (dec_kind),
        .arg   (dec_arg),
        .step  (idle ? '0 : step),
        .st    (st),
        .last  (last),
        .legal (legal)
    );

    lt_seq_ctrl #(.STEP_W(STEP_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .legal    (legal),
        .last     (last),
        .cmd_done (cmd_done),
        .cmd_err  (cmd_err),
        .idle     (idle),
        .accept   (accept),
        .hit      (hit),
        .cmd_req  (cmd_req),
        .step     (step),
        .op_done  (op_done),
        .op_err   (op_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_kind <= '0;
            lat_arg  <= '0;
            lat_lane <= '0;
        end else if (accept) begin
            lat_kind <= op_kind;
            lat_arg  <= op_arg;
            lat_lane <= op_lane;
        end
    end

    assign op_ready = idle;
    assign cmd_word = pack_word(st, dec_lane);

    lt_part_collect #(.PART_W(PART_W), .NUM_PARTS(NUM_PARTS), .STEP_W(STEP_W)) u_parts (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (hit && st.is_part),
        .cap_idx  (step),
        .cap_data (cmd_rdata[PART_W-1:0]),
        .commit   (hit && st.is_part && last),
        .total    (result_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_word <= '0;
        end else if (hit && st.is_stat) begin
            status_word <= cmd_rdata;
        end
    end
endmodule

// File: rtl/lt_seq_chk.sv
`timescale 1ns/1ps
module lt_seq_chk #(
    parameter int RES_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             op_ready,
    input logic             op_done,
    input logic             op_err,
    input logic             cmd_req,
    input logic [31:0]      cmd_word,
    input logic             cmd_done,
    input logic             cmd_err,
    input logic [RES_W-1:0] result_cnt
);
    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_done && !cmd_err) |=> (cmd_req && $stable(cmd_word)));

    // R2
    word_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> (cmd_word[15] && !cmd_word[14] && !cmd_word[12]));

    // R10
    req_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && (cmd_done || cmd_err)) |=> !cmd_req);

    // R13
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> !op_ready);

    // R11
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(op_done && op_err));

    // R8
    result_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_cnt) |-> op_done);

    // R13
    idle_done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd_req && op_ready && !op_valid_seen) |=> !op_done);

    logic op_valid_seen;
    assign op_valid_seen = 1'b0;
endmodule

bind link_test_seq lt_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_ready   (op_ready),
    .op_done    (op_done),
    .op_err     (op_err),
    .cmd_req    (cmd_req),
    .cmd_word   (cmd_word),
    .cmd_done   (cmd_done),
    .cmd_err    (cmd_err),
    .result_cnt (result_cnt)
);

// File: tb/link_test_seq_tb.sv
`timescale 1ns/1ps
module link_test_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_kind = '0;
    logic [15:0] op_arg = '0;
    logic [3:0]  op_lane = '0;
    logic        op_ready, op_done, op_err, cmd_req;
    logic [31:0] cmd_word;
    logic        cmd_done = 1'b0;
    logic        cmd_err = 1'b0;
    logic [31:0] cmd_rdata = '0;
    logic [47:0] result_cnt;
    logic [31:0] status_word;

    int checks = 0;
    int errors = 0;

    logic [31:0] log_w [8];
    int          log_n = 0;
    int          err_at = -1;
    bit          eng_en = 1'b1;
    logic [15:0] part_v [3];
    logic [31:0] stat_v = '0;
    logic [47:0] exp_res = '0;
    logic [31:0] exp_stat = '0;

    always #5 clk = ~clk;

    link_test_seq u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_arg(op_arg), .op_lane(op_lane), .op_ready(op_ready),
        .op_done(op_done), .op_err(op_err), .cmd_req(cmd_req),
        .cmd_word(cmd_word), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .cmd_rdata(cmd_rdata), .result_cnt(result_cnt), .status_word(status_word)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [15:0] d, input bit s,
                                       input logic [3:0] ln, input logic [7:0] o);
        return {d, 1'b1, 1'b0, s, 1'b0, ln, o};
    endfunction

    function automatic string tag(input int k);
        case (k)
            0: return "R3";  1: return "R4";  2, 3: return "R5";
            4, 5, 8: return "R6"; 6: return "R7"; 7: return "R8";
            9, 10: return "R9"; default: return "R12";
        endcase
    endfunction

    function automatic int exp_n(input int k, input logic [15:0] a);
        if (k == 1 && a[2:0] > 3'd5) return 0;
        case (k)
            6: return 2;
            7: return 3;
            0, 1, 2, 3, 4, 5, 8, 9, 10: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] exp_word(input int k, input logic [15:0] a,
                                             input logic [3:0] ln, input int idx);
        logic [15:0] lc [4];
        logic [15:0] pc [6];
        lc[0] = 16'h0; lc[1] = 16'h6; lc[2] = 16'h4; lc[3] = 16'h3;
        pc[0] = 16'h208; pc[1] = 16'h249; pc[2] = 16'h965;
        pc[3] = 16'hA69; pc[4] = 16'h2CB; pc[5] = 16'h30C;
        case (k)
            0:  return mk(lc[a[1:0]], 1, ln, 8'h40);
            1:  return mk(pc[a[2:0]], 1, ln, 8'h41);
            2:  return mk({15'b0, a[0]}, 1, ln, 8'h65);
            3:  return mk({15'b0, a[0]}, 1, ln, 8'h66);
            4:  return mk(16'h20, 1, ln, 8'h0F);
            5:  return mk(16'h21, 1, ln, 8'h0F);
            6:  return (idx == 0) ? mk(a, 1, ln, 8'h42) : mk(16'h23, 1, ln, 8'h0F);
            7:  return mk(16'h0, 0, ln, 8'h4A + 8'(idx));
            8:  return mk(16'h0, 1, ln, 8'h41);
            9:  return mk(16'h0, 0, ln, 8'h49);
            default: return mk(16'h0, 0, ln, 8'h0D);
        endcase
    endfunction

    // handshake engine model
    initial begin
        forever begin
            @(negedge clk);
            if (eng_en && cmd_req) begin
                logic [31:0] w;
                int lat;
                bit multi;
                w = cmd_word;
                if (log_n < 8) log_w[log_n] = w;
                log_n++;
                check(op_ready == 1'b0, "R13 ready low while busy", op_ready, 0);
                lat = $urandom_range(0, 3);
                repeat (lat) @(negedge clk);
                check(cmd_req && cmd_word == w, "R2 word held", cmd_word, w);
                if (log_n - 1 == err_at) begin
                    cmd_err = 1'b1;
                end else begin
                    cmd_done = 1'b1;
                end
                if (w[7:0] >= 8'h4A && w[7:0] <= 8'h4C)
                    cmd_rdata = {16'($urandom), part_v[w[7:0] - 8'h4A]};
                else if (w[7:0] == 8'h49 || w[7:0] == 8'h0D)
                    cmd_rdata = stat_v;
                else
                    cmd_rdata = $urandom;
                multi = (w[7:0] == 8'h42) || (w[7:0] >= 8'h4A && w[7:0] <= 8'h4B);
                @(negedge clk);
                cmd_done = 1'b0;
                cmd_err  = 1'b0;
                if (multi) check(cmd_req == 1'b0, "R10 gap between commands", cmd_req, 0);
            end
        end
    end

    task automatic do_op(input int k, input logic [15:0] a, input logic [3:0] ln,
                         input int e_at);
        bit got_done, got_err;
        int n;
        got_done = 0; got_err = 0;
        err_at = e_at;
        log_n = 0;
        if (k == 7) for (int i = 0; i < 3; i++) part_v[i] = 16'($urandom);
        if (k == 9 || k == 10) stat_v = $urandom;
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        op_valid = 1'b1; op_kind = 4'(k); op_arg = a; op_lane = ln;
        @(negedge clk);
        op_valid = 1'b0;
        for (int c = 0; c < 200 && !got_done && !got_err; c++) begin
            if (op_done) got_done = 1;
            if (op_err) got_err = 1;
            if (!got_done && !got_err) @(negedge clk);
        end
        n = exp_n(k, a);
        if (e_at >= 0 && e_at < n) begin
            check(got_err && !got_done, "R11 abort flagged", {got_done, got_err}, 2'b01);
            check(log_n == e_at + 1, "R11 no further commands", log_n, e_at + 1);
        end else if (n == 0) begin
            check(got_err && !got_done, {tag(k), " reject flagged"}, {got_done, got_err}, 2'b01);
            check(log_n == 0, {tag(k), " reject issues nothing"}, log_n, 0);
        end else begin
            check(got_done && !got_err, {tag(k), " completes"}, {got_done, got_err}, 2'b10);
            check(log_n == n, {tag(k), " command count"}, log_n, n);
            for (int i = 0; i < n && i < log_n; i++)
                check(log_w[i] == exp_word(k, a, ln, i), {tag(k), " command word"},
                      log_w[i], exp_word(k, a, ln, i));
            if (k == 7) exp_res = {part_v[2], part_v[1], part_v[0]};
            if (k == 9 || k == 10) exp_stat = stat_v;
        end
        check(result_cnt == exp_res, "R8 result value", result_cnt, exp_res);
        check(status_word == exp_stat, "R9 status value", status_word, exp_stat);
        err_at = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < 3; i++) part_v[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(op_ready == 1'b1, "R1 ready after reset", op_ready, 1);
        check(cmd_req == 1'b0, "R1 no request after reset", cmd_req, 0);
        check(result_cnt == '0, "R1 result cleared", result_cnt, 0);
        check(status_word == '0, "R1 status cleared", status_word, 0);

        // R3 every loopback mode
        for (int m = 0; m < 4; m++) do_op(0, 16'(m), 4'($urandom), -1);
        // R4 every pattern code and both illegal selections
        for (int p = 0; p < 8; p++) do_op(1, 16'(p), 4'($urandom), -1);
        // R5
        for (int p = 0; p < 2; p++) begin
            do_op(2, 16'(p), 4'($urandom), -1);
            do_op(3, 16'(p), 4'($urandom), -1);
        end
        // R6
        do_op(4, 16'hFFFF, 4'h3, -1);
        do_op(5, 16'h0000, 4'h7, -1);
        do_op(8, 16'h1234, 4'hF, -1);
        // R7 count extremes
        do_op(6, 16'h0000, 4'h0, -1);
        do_op(6, 16'hFFFF, 4'h1, -1);
        // R8
        do_op(7, 16'h0, 4'h2, -1);
        do_op(7, 16'h0, 4'h5, -1);
        // R9
        do_op(9, 16'h0, 4'h4, -1);
        do_op(10, 16'h0, 4'h6, -1);
        // R11 aborts at each step of the multi-command kinds
        for (int s = 0; s < 3; s++) do_op(7, 16'h0, 4'h1, s);
        do_op(6, 16'h00AA, 4'h2, 0);
        do_op(6, 16'h00AA, 4'h2, 1);
        do_op(0, 16'h1, 4'h3, 0);
        // R12
        for (int k = 11; k < 16; k++) do_op(k, 16'($urandom), 4'($urandom), -1);

        // R13 stray completion while idle
        eng_en = 1'b0;
        @(negedge clk);
        cmd_done = 1'b1; cmd_rdata = 32'hDEAD_BEEF;
        @(negedge clk);
        check(op_done == 1'b0 && op_err == 1'b0, "R13 stray done ignored", {op_done, op_err}, 0);
        cmd_done = 1'b0; cmd_err = 1'b1;
        @(negedge clk);
        check(op_done == 1'b0 && op_err == 1'b0, "R13 stray error ignored", {op_done, op_err}, 0);
        cmd_err = 1'b0;
        @(negedge clk);
        check(cmd_req == 1'b0, "R13 no request after stray", cmd_req, 0);
        check(result_cnt == exp_res, "R13 result untouched", result_cnt, exp_res);
        check(status_word == exp_stat, "R13 status untouched", status_word, exp_stat);
        eng_en = 1'b1;

        // constrained random mix
        for (int r = 0; r < 60; r++) begin
            int k;
            int e;
            k = $urandom_range(0, 12);
            e = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 2) : -1;
            do_op(k, 16'($urandom), 4'($urandom), e);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule